// File: doc/BRIEF.md
# Local Interrupt Controller Register File

This block holds the software-visible registers of a per-CPU local interrupt controller. It is reached over a small memory-mapped request port that carries an address, a byte length of 1, 2 or 4, a write flag and write data. Each accepted request produces one response one cycle later. The response carries read data and an error flag.

Each register applies its own write rule as the write lands:
- Some fields are cut to the bits the register keeps.
- Some fields have ones forced into them.
- The pending bit of the command word is cleared.

A disable written to the spurious-vector register masks every local vector table (LVT) entry in the same cycle. Sub-word writes read the containing word, replace the addressed lane and store the merged word, so the register rules see a full word. Interrupt delivery, the timer countdown and inter-processor messaging belong to other blocks. The request, in-service and trigger-mode array words therefore read as zero here, and so does the current-count word.

The request port follows valid/ready rules. `req_ready` is always high, so a request is taken on every clock edge where `req_valid` is high. The response side has no back-pressure. A requester that cannot take `rsp_valid` in the cycle after its request loses that response.

Top module: `lapic_regfile`

## Requirements
- R1: After reset:
  - The destination-format word (offset 0x0E0) reads 0xFFFFFFFF.
  - The spurious-vector word (0x0F0) reads 0x000000FF.
  - Every LVT entry (0x320 to 0x370, stride 0x10) reads 0x00010000.
  - Task priority, logical destination, both command words, initial count, current count and divide config read 0.
  - `sw_disabled` is 1.
- R2: `req_ready` is always 1. Every cycle with `req_valid` high is followed, one cycle later, by exactly one cycle of `rsp_valid` high. Without a request, `rsp_valid` stays low.
- R3: A 1-byte read may start at any byte. A 2-byte read starting at byte 3 of a word is an error. A 4-byte read that is not word-aligned is an error. Any length other than 1, 2 or 4 is an error. A sub-word read returns the addressed bytes right-aligned. An error raises `rsp_err` for one cycle only.
- R4: A read at an address above 0x3E3 returns 0 with no error, whatever its alignment. Words at +4, +8 and +12 inside each 16-byte slot read 0.
- R5: A write of 1 or 2 bytes replaces only the addressed lane of the current word. The merged word then passes through that register's write rule.
- R6: These writes are errors that change no register and leave `sw_disabled` unchanged:
  - a 2-byte write at an odd address;
  - a 4-byte write that is not word-aligned;
  - a write with any length other than 1, 2 or 4.
- R7: Write masks apply per register:
  - task priority (0x080) keeps [7:0];
  - logical destination (0x0D0) keeps [31:24];
  - spurious vector keeps [9:0];
  - high command word (0x310) keeps [31:24];
  - divide config (0x3E0) keeps bits 0, 1 and 3.
- R8: A write to the destination-format word stores the value ORed with 0x0FFFFFFF.
- R9: A spurious-vector write with bit 8 clear sets `sw_disabled` and sets bit 16 of all six LVT entries on the same edge. A spurious-vector write with bit 8 set clears `sw_disabled`.
- R10: Each LVT write stores the value ANDed with that entry's mask. The masks are:

  | Entry | Mask |
  |---|---|
  | timer | 0x000300FF |
  | thermal | 0x000107FF |
  | perf | 0x000107FF |
  | local input 0 | 0x0001A7FF |
  | local input 1 | 0x0001A7FF |
  | error | 0x000100FF |

  While `sw_disabled` is 1, bit 16 is set before the mask is applied.
- R11: A write to the low command word (0x300) stores the value with bit 12 cleared.
- R12: The following writes are ignored without error and leave every readable value unchanged:
  - writes to the ID word (0x020) and the version word (0x030);
  - writes to the error-status word (0x280) and the end-of-interrupt word (0x0B0);
  - writes to the current count (0x390);
  - writes to the array words (0x100 to 0x270);
  - writes to reserved words.
- R13: The ID word reads CPU_INDEX*2 shifted left by 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the register page |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data, right-aligned (0 for writes and errors) |
| rsp_err | output | 1 | Illegal access pulse |
| sw_disabled | output | 1 | Software-disabled state |

## Verification
Two functions can act on the same clock edge: the sub-word read-modify-write merge, and the software-disable side effect that masks all LVT entries. The bench brings them together with a single 1-byte write that clears only the byte holding the enable bit of the spurious-vector word. The resulting spurious-vector value must keep its untouched lane. In the same step, `sw_disabled` must rise and each LVT entry must keep its earlier contents with bit 16 added. A second pairing writes an LVT entry while the block is disabled, so that mask forcing and the per-entry mask act on the same stored value.

// File: rtl/lapic_regs_pkg.sv
package lapic_regs_pkg;
  typedef logic [31:0] word_t;

  localparam int LVT_COUNT = 6;
  localparam int LVT_MASK_BIT = 16;
  localparam int SPUR_EN_BIT = 8;
  localparam int PEND_BIT = 12;
  localparam logic [11:0] LAST_BYTE = 12'h3E3;

  // slot index = byte offset >> 4
  localparam logic [7:0] IX_ID    = 8'h02;
  localparam logic [7:0] IX_VER   = 8'h03;
  localparam logic [7:0] IX_TPRI  = 8'h08;
  localparam logic [7:0] IX_LDEST = 8'h0D;
  localparam logic [7:0] IX_DFMT  = 8'h0E;
  localparam logic [7:0] IX_SPUR  = 8'h0F;
  localparam logic [7:0] IX_CMDLO = 8'h30;
  localparam logic [7:0] IX_CMDHI = 8'h31;
  localparam logic [7:0] IX_LVT0  = 8'h32;
  localparam logic [7:0] IX_ICNT  = 8'h38;
  localparam logic [7:0] IX_DIV   = 8'h3E;

  localparam word_t M_TPRI  = 32'h0000_00FF;
  localparam word_t M_SPUR  = 32'h0000_03FF;
  localparam word_t M_HIGH8 = 32'hFF00_0000;
  localparam word_t M_DIV   = 32'h0000_000B;
  localparam word_t F_DFMT  = 32'h0FFF_FFFF;

  function automatic word_t lvt_wmask(input int idx);
    case (idx)
      0:       return 32'h0003_00FF;
      1, 2:    return 32'h0001_07FF;
      3, 4:    return 32'h0001_A7FF;
      default: return 32'h0001_00FF;
    endcase
  endfunction
endpackage

// File: rtl/lapic_lane_unit.sv
module lapic_lane_unit
  import lapic_regs_pkg::*;
(
  input  logic [1:0] byte_sel,
  input  logic [2:0] len,
  input  logic       is_write,
  input  word_t      cur_word,
  input  word_t      wdata,
  output word_t      rd_val,
  output word_t      merged,
  output logic       bad
);
  logic [4:0] sh;
  word_t      shifted;
  word_t      lane_mask;

  assign sh      = {byte_sel, 3'b000};
  assign shifted = cur_word >> sh;

  always_comb begin
    bad       = 1'b0;
    rd_val    = '0;
    lane_mask = '0;
    merged    = cur_word;
    case (len)
      3'd1: begin
        rd_val    = shifted & 32'hFF;
        lane_mask = 32'hFF << sh;
        merged    = (cur_word & ~lane_mask) | ((wdata & 32'hFF) << sh);
      end
      3'd2: begin
        rd_val    = shifted & 32'hFFFF;
        lane_mask = 32'hFFFF << sh;
        merged    = (cur_word & ~lane_mask) | ((wdata & 32'hFFFF) << sh);
        bad       = is_write ? byte_sel[0] : (byte_sel == 2'd3);
      end
      3'd4: begin
        rd_val = cur_word;
        merged = wdata;
        bad    = (byte_sel != 2'd0);
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/lapic_lvt_bank.sv
module lapic_lvt_bank
  import lapic_regs_pkg::*;
#(
  parameter int N = LVT_COUNT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_sel,
  input  word_t               wr_val,
  input  logic                sw_dis,
  input  logic                force_all,
  output logic [N-1:0][31:0]  lvt_q
);
  localparam word_t MBIT = word_t'(1) << LVT_MASK_BIT;

  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam word_t WM = lvt_wmask(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lvt_q[i] <= MBIT;
      else if (force_all)  lvt_q[i] <= lvt_q[i] | MBIT;
      else if (wr_sel[i])  lvt_q[i] <= (wr_val | (sw_dis ? MBIT : '0)) & WM;
    end

    // R10
    dis_wr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[i] && sw_dis) |=> lvt_q[i][LVT_MASK_BIT]);

    // R9
    force_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_all |=> lvt_q[i][LVT_MASK_BIT]);
  end
endmodule

// File: rtl/lapic_regfile.sv
module lapic_regfile
  import lapic_regs_pkg::*;
#(
  parameter int    CPU_INDEX = 0,
  parameter word_t VERSION   = 32'h0005_0014,
  parameter int    AW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_len,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_err,
  output logic          sw_disabled
);
  localparam word_t ID_VAL = word_t'(CPU_INDEX * 2) << 24;

  logic [7:0] idx;
  logic       in_range, slot_hit, lane_bad, acc_err, wr_fire;
  word_t      cur_word, rd_val, merged;
  logic [7:0] lvt_rel;
  logic [LVT_COUNT-1:0] lvt_sel;
  logic [LVT_COUNT-1:0][31:0] lvt_q;
  logic       force_all;

  logic [7:0] tpri;
  word_t      ldest, dfmt, cmd_lo, cmd_hi, icnt;
  logic [9:0] spur;
  logic [3:0] divc;
  logic       sw_dis;

  assign req_ready   = 1'b1;
  assign sw_disabled = sw_dis;
  assign idx         = 8'(req_addr >> 4);
  assign in_range    = 12'(req_addr) <= LAST_BYTE;
  assign slot_hit    = in_range && (req_addr[3:2] == 2'b00);
  assign lvt_rel     = idx - IX_LVT0;

  always_comb begin
    cur_word = '0;
    if (slot_hit) begin
      case (idx)
        IX_ID:    cur_word = ID_VAL;
        IX_VER:   cur_word = VERSION;
        IX_TPRI:  cur_word = {24'd0, tpri};
        IX_LDEST: cur_word = ldest;
        IX_DFMT:  cur_word = dfmt;
        IX_SPUR:  cur_word = {22'd0, spur};
        IX_CMDLO: cur_word = cmd_lo;
        IX_CMDHI: cur_word = cmd_hi;
        IX_ICNT:  cur_word = icnt;
        IX_DIV:   cur_word = {28'd0, divc};
        default: begin
          for (int i = 0; i < LVT_COUNT; i++)
            if (lvt_rel == 8'(i)) cur_word = lvt_q[i];
        end
      endcase
    end
  end

  lapic_lane_unit u_lane (
    .byte_sel (req_addr[1:0]),
    .len      (req_len),
    .is_write (req_write),
    .cur_word (cur_word),
    .wdata    (req_wdata),
    .rd_val   (rd_val),
    .merged   (merged),
    .bad      (lane_bad)
  );

  assign acc_err   = req_valid && lane_bad && (req_write || in_range);
  assign wr_fire   = req_valid && req_write && !lane_bad && slot_hit;
  assign force_all = wr_fire && (idx == IX_SPUR) && !merged[SPUR_EN_BIT];

  always_comb begin
    lvt_sel = '0;
    for (int i = 0; i < LVT_COUNT; i++)
      lvt_sel[i] = wr_fire && (lvt_rel == 8'(i));
  end

  lapic_lvt_bank #(.N(LVT_COUNT)) u_lvt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sel    (lvt_sel),
    .wr_val    (merged),
    .sw_dis    (sw_dis),
    .force_all (force_all),
    .lvt_q     (lvt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpri   <= '0;
      ldest  <= '0;
      dfmt   <= '1;
      spur   <= 10'h0FF;
      cmd_lo <= '0;
      cmd_hi <= '0;
      icnt   <= '0;
      divc   <= '0;
      sw_dis <= 1'b1;
    end else if (wr_fire) begin
      case (idx)
        IX_TPRI:  tpri   <= 8'(merged & M_TPRI);
        IX_LDEST: ldest  <= merged & M_HIGH8;
        IX_DFMT:  dfmt   <= merged | F_DFMT;
        IX_SPUR: begin
          spur   <= 10'(merged & M_SPUR);
          sw_dis <= !merged[SPUR_EN_BIT];
        end
        IX_CMDLO: cmd_lo <= merged & ~(word_t'(1) << PEND_BIT);
        IX_CMDHI: cmd_hi <= merged & M_HIGH8;
        IX_ICNT:  icnt   <= merged;
        IX_DIV:   divc   <= 4'(merged & M_DIV);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= acc_err;
      rsp_rdata <= (req_valid && !req_write && !acc_err) ? rd_val : '0;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R6
  err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> ($stable(cmd_lo) && $stable(icnt) && $stable(spur) && $stable(sw_dis)));

  // R8
  dfmt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && idx == IX_DFMT) |=> (dfmt[27:0] == 28'hFFFFFFF));

  // R11
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && idx == IX_CMDLO) |=> !cmd_lo[PEND_BIT]);

  // R9
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_dis) |-> spur[SPUR_EN_BIT]);

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
endmodule

// File: tb/lapic_regfile_test.sv
`timescale 1ns/1ps
module lapic_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_len = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        sw_disabled;

  int checks = 0;
  int fails = 0;
  logic [31:0] got;
  logic        gerr;

  always #10 clk = ~clk;

  lapic_regfile #(.CPU_INDEX(3)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .sw_disabled(sw_disabled)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [2:0] l,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = l; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    got  = rsp_rdata;
    gerr = rsp_err;
    check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic rd_expect(input string tag, input logic [11:0] a, input logic [2:0] l,
                           input logic [31:0] exp, input logic exp_err);
    access(1'b0, a, l, 32'd0);
    check(tag, got, exp);
    check({tag, " err"}, {31'd0, gerr}, {31'd0, exp_err});
  endtask

  task automatic wr_ok(input string tag, input logic [11:0] a, input logic [2:0] l,
                       input logic [31:0] d);
    access(1'b1, a, l, d);
    check({tag, " write err"}, {31'd0, gerr}, 32'd0);
  endtask

  task automatic test_reset;
    check("R2 ready", {31'd0, req_ready}, 32'd1);
    check("R2 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 sw_disabled", {31'd0, sw_disabled}, 32'd1);
    rd_expect("R13 id", 12'h020, 3'd4, 32'h0600_0000, 1'b0);
    rd_expect("R1 dfmt", 12'h0E0, 3'd4, 32'hFFFF_FFFF, 1'b0);
    rd_expect("R1 spur", 12'h0F0, 3'd4, 32'h0000_00FF, 1'b0);
    for (int i = 0; i < 6; i++)
      rd_expect("R1 lvt", 12'h320 + 12'(i * 16), 3'd4, 32'h0001_0000, 1'b0);
    rd_expect("R1 tpri", 12'h080, 3'd4, 32'd0, 1'b0);
    rd_expect("R1 cmdlo", 12'h300, 3'd4, 32'd0, 1'b0);
    rd_expect("R1 icnt", 12'h380, 3'd4, 32'd0, 1'b0);
    rd_expect("R1 div", 12'h3E0, 3'd4, 32'd0, 1'b0);
  endtask

  task automatic test_masks;
    wr_ok("R7", 12'h080, 3'd4, 32'hFFFF_FF5A);
    rd_expect("R7 tpri", 12'h080, 3'd4, 32'h0000_005A, 1'b0);
    wr_ok("R7", 12'h310, 3'd4, 32'h1234_5678);
    rd_expect("R7 cmdhi", 12'h310, 3'd4, 32'h1200_0000, 1'b0);
    wr_ok("R7", 12'h3E0, 3'd4, 32'hFFFF_FFFF);
    rd_expect("R7 div", 12'h3E0, 3'd4, 32'h0000_000B, 1'b0);
    wr_ok("R7", 12'h0D0, 3'd4, 32'hABCD_EF12);
    rd_expect("R7 ldest", 12'h0D0, 3'd4, 32'hAB00_0000, 1'b0);
    wr_ok("R8", 12'h0E0, 3'd4, 32'h0000_0000);
    rd_expect("R8 dfmt", 12'h0E0, 3'd4, 32'h0FFF_FFFF, 1'b0);
    wr_ok("R11", 12'h300, 3'd4, 32'hFFFF_FFFF);
    rd_expect("R11 cmdlo", 12'h300, 3'd4, 32'hFFFF_EFFF, 1'b0);
  endtask

  task automatic test_disable;
    wr_ok("R9", 12'h0F0, 3'd4, 32'h0000_01FF);
    check("R9 enabled", {31'd0, sw_disabled}, 32'd0);
    rd_expect("R7 spur", 12'h0F0, 3'd4, 32'h0000_01FF, 1'b0);
    wr_ok("R10", 12'h320, 3'd4, 32'h0002_00AB);
    rd_expect("R10 timer", 12'h320, 3'd4, 32'h0002_00AB, 1'b0);
    wr_ok("R10", 12'h360, 3'd4, 32'h0000_0041);
    wr_ok("R9", 12'h0F0, 3'd4, 32'h0000_00FF);
    check("R9 disabled", {31'd0, sw_disabled}, 32'd1);
    rd_expect("R9 timer masked", 12'h320, 3'd4, 32'h0003_00AB, 1'b0);
    rd_expect("R9 lint1 masked", 12'h360, 3'd4, 32'h0001_0041, 1'b0);
    wr_ok("R10", 12'h350, 3'd4, 32'h0000_8730);
    rd_expect("R10 forced", 12'h350, 3'd4, 32'h0001_8730, 1'b0);
    wr_ok("R9", 12'h0F0, 3'd4, 32'h0000_0100);
    check("R9 reenabled", {31'd0, sw_disabled}, 32'd0);
    wr_ok("R10", 12'h350, 3'd4, 32'h0004_8730);
    rd_expect("R10 lint0 mask", 12'h350, 3'd4, 32'h0000_8730, 1'b0);
    wr_ok("R10", 12'h370, 3'd4, 32'hFFFF_FFFF);
    rd_expect("R10 error mask", 12'h370, 3'd4, 32'h0001_00FF, 1'b0);
  endtask

  task automatic test_same_cycle;
    wr_ok("R10", 12'h360, 3'd4, 32'h0000_0041);
    wr_ok("R5", 12'h0F1, 3'd1, 32'h0000_0000);
    check("R9 byte disable", {31'd0, sw_disabled}, 32'd1);
    rd_expect("R5 spur merged", 12'h0F0, 3'd4, 32'h0000_0000, 1'b0);
    rd_expect("R9 lint1", 12'h360, 3'd4, 32'h0001_0041, 1'b0);
    rd_expect("R9 lint0", 12'h350, 3'd4, 32'h0001_8730, 1'b0);
  endtask

  task automatic test_subword;
    wr_ok("R5", 12'h380, 3'd4, 32'h1122_3344);
    wr_ok("R5", 12'h382, 3'd1, 32'h0000_00AA);
    rd_expect("R5 byte merge", 12'h380, 3'd4, 32'h11AA_3344, 1'b0);
    wr_ok("R5", 12'h382, 3'd2, 32'h0000_BEEF);
    rd_expect("R5 half merge", 12'h380, 3'd4, 32'hBEEF_3344, 1'b0);
    rd_expect("R3 byte read", 12'h381, 3'd1, 32'h0000_0033, 1'b0);
    rd_expect("R3 half read odd", 12'h381, 3'd2, 32'h0000_EF33, 1'b0);
    rd_expect("R3 top byte", 12'h383, 3'd1, 32'h0000_00BE, 1'b0);
    wr_ok("R11", 12'h301, 3'd1, 32'h0000_0077);
    rd_expect("R11 merged cmdlo", 12'h300, 3'd4, 32'hFFFF_67FF, 1'b0);
  endtask

  task automatic test_errors;
    rd_expect("R3 half at 3", 12'h383, 3'd2, 32'd0, 1'b1);
    @(negedge clk);
    check("R3 one-cycle pulse", {31'd0, rsp_err}, 32'd0);
    rd_expect("R3 word unaligned", 12'h382, 3'd4, 32'd0, 1'b1);
    rd_expect("R3 bad len", 12'h380, 3'd3, 32'd0, 1'b1);
    access(1'b1, 12'h381, 3'd2, 32'h0000_0000);
    check("R6 half odd err", {31'd0, gerr}, 32'd1);
    access(1'b1, 12'h382, 3'd4, 32'h0000_0000);
    check("R6 word unaligned err", {31'd0, gerr}, 32'd1);
    access(1'b1, 12'h380, 3'd0, 32'h0000_0000);
    check("R6 bad len err", {31'd0, gerr}, 32'd1);
    rd_expect("R6 unchanged", 12'h380, 3'd4, 32'hBEEF_3344, 1'b0);
    access(1'b1, 12'h0F2, 3'd4, 32'h0000_01FF);
    check("R6 spur err", {31'd0, gerr}, 32'd1);
    check("R6 flag kept", {31'd0, sw_disabled}, 32'd1);
  endtask

  task automatic test_range_ro;
    rd_expect("R4 above", 12'h3F0, 3'd4, 32'd0, 1'b0);
    rd_expect("R4 just above", 12'h3E4, 3'd4, 32'd0, 1'b0);
    rd_expect("R4 above misaligned", 12'h3E7, 3'd4, 32'd0, 1'b0);
    rd_expect("R4 reserved word", 12'h384, 3'd4, 32'd0, 1'b0);
    wr_ok("R12", 12'h020, 3'd4, 32'hFFFF_FFFF);
    rd_expect("R12 id kept", 12'h020, 3'd4, 32'h0600_0000, 1'b0);
    wr_ok("R12", 12'h390, 3'd4, 32'h1234_5678);
    rd_expect("R12 curcount", 12'h390, 3'd4, 32'd0, 1'b0);
    wr_ok("R12", 12'h0B0, 3'd4, 32'h0000_0001);
    rd_expect("R12 eoi", 12'h0B0, 3'd4, 32'd0, 1'b0);
    wr_ok("R12", 12'h100, 3'd4, 32'hFFFF_FFFF);
    rd_expect("R12 array", 12'h100, 3'd4, 32'd0, 1'b0);
    wr_ok("R12", 12'h280, 3'd4, 32'hFFFF_FFFF);
    rd_expect("R12 esr", 12'h280, 3'd4, 32'd0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_masks();
    test_disable();
    test_same_cycle();
    test_subword();
    test_errors();
    test_range_ro();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule